// File: doc/BRIEF.md
# Transmit Byte Handshake Interface

This block sits between a processor's register write bus and a packet serializer. Software starts a packet by writing the start command to a command register. The block then raises a sticky ready flag each time its single-byte holding slot is free. Software clears the flag, writes the next byte into the data register, and waits for the flag again. Every transfer is paced by that flag alone.

The first byte after the start command is the packet length. It counts only the payload bytes that follow it. Each byte written is offered to the serializer on a valid/ready stream and held there until the serializer accepts it. When the last payload byte has been accepted, the block goes back to idle and pulses a done output. A length of zero ends the packet as soon as the length byte itself has been accepted.

Writes that arrive when no byte can be taken are flagged as errors and dropped. A start command received while a packet is in progress has no effect.

Top module: `txbyte_link`

## Requirements
- R1: After reset the block is idle: busy, readyFlag, outValid, donePulse and errPulse are all low.
- R2: A bus write of value 0x03 to address 0 while idle makes busy and readyFlag high in the next cycle. A write of any other value to address 0 is ignored.
- R3: readyFlag stays high until a bus write to address 2 clears it; the write data is ignored. A set in the same cycle as a clear wins. A write to address 3 has no effect.
- R4: A write to address 1 while the slot is free presents that byte on outData with outValid high in the next cycle. The byte is held stable until a cycle with outReady high.
- R5: The first byte after the start command is taken as the payload length N. readyFlag is raised again in the cycle after each accepted byte when more bytes are due, and never while a byte is pending.
- R6: In the cycle after the serializer accepts the N-th payload byte, busy is low and donePulse is high for exactly one cycle.
- R7: If the length byte is 0, done follows directly in the cycle after the length byte is accepted, and no payload is taken.
- R8: A write to address 1 while idle, or while a byte is still pending, pulses errPulse in the next cycle. The byte is dropped, leaving outData and the packet count unchanged.
- R9: A start command written while busy is ignored, and the packet still ends after exactly N payload bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Bus write enable |
| regAddr | input | 2 | 0 command, 1 data, 2 flag clear, 3 unused |
| regWrData | input | 8 | Bus write data |
| readyFlag | output | 1 | Sticky ready-for-byte flag |
| busy | output | 1 | Packet in progress |
| donePulse | output | 1 | One-cycle end-of-packet pulse |
| errPulse | output | 1 | One-cycle dropped-write pulse |
| outValid | output | 1 | Byte offered to serializer |
| outData | output | 8 | Offered byte |
| outReady | input | 1 | Serializer accepts byte |

## Verification
The hardest situation to reach from the ports is a data write that lands while a byte is still pending. It can only happen when the serializer stalls after software has already written into the slot. The bench reaches it by holding outReady low after a payload write and writing the data register again. It then checks that the offered byte is unchanged and that the packet still ends after the stated count. A start command injected in the middle of a stalled packet is driven the same way.

// File: rtl/txbyte_pkg.sv
package txbyte_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SEND} txState_e;

  typedef struct packed {
    logic loadByte;
    logic takeLen;
    logic countDown;
    logic setFlag;
    logic doneHit;
    logic errHit;
  } txCtl_s;
endpackage

// File: rtl/txbyte_ctrl.sv
module txbyte_ctrl
  import txbyte_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   startWr,
  input  logic   dataWr,
  input  logic   outReady,
  input  logic   holdIsZero,
  input  logic   lastPayload,
  output txCtl_s ctl,
  output logic   busy,
  output logic   sendActive
);
  txState_e state, nextState;
  logic lenPhase;

  always_comb begin
    ctl = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (dataWr) ctl.errHit = 1'b1;
        if (startWr) begin
          nextState = ST_WAIT;
          ctl.setFlag = 1'b1;
        end
      end
      ST_WAIT: begin
        if (dataWr) begin
          ctl.loadByte = 1'b1;
          nextState = ST_SEND;
        end
      end
      ST_SEND: begin
        if (dataWr) ctl.errHit = 1'b1;
        if (outReady) begin
          if (lenPhase) begin
            ctl.takeLen = 1'b1;
            if (holdIsZero) begin
              ctl.doneHit = 1'b1;
              nextState = ST_IDLE;
            end else begin
              ctl.setFlag = 1'b1;
              nextState = ST_WAIT;
            end
          end else begin
            ctl.countDown = 1'b1;
            if (lastPayload) begin
              ctl.doneHit = 1'b1;
              nextState = ST_IDLE;
            end else begin
              ctl.setFlag = 1'b1;
              nextState = ST_WAIT;
            end
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lenPhase <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && startWr) lenPhase <= 1'b1;
      else if (ctl.takeLen) lenPhase <= 1'b0;
    end
  end

  assign busy = (state != ST_IDLE);
  assign sendActive = (state == ST_SEND);
endmodule

// File: rtl/txbyte_dpath.sv
module txbyte_dpath
  import txbyte_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtl_s            ctl,
  input  logic              clrWr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] holdByte,
  output logic              holdIsZero,
  output logic              lastPayload,
  output logic              flagQ,
  output logic              doneQ,
  output logic              errQ
);
  logic [DATA_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdByte <= '0;
      remain   <= '0;
      flagQ    <= 1'b0;
      doneQ    <= 1'b0;
      errQ     <= 1'b0;
    end else begin
      if (ctl.loadByte) holdByte <= wrData;
      if (ctl.takeLen) remain <= holdByte;
      else if (ctl.countDown) remain <= remain - 1'b1;
      if (ctl.setFlag) flagQ <= 1'b1;
      else if (clrWr) flagQ <= 1'b0;
      doneQ <= ctl.doneHit;
      errQ  <= ctl.errHit;
    end
  end

  assign holdIsZero  = (holdByte == '0);
  assign lastPayload = (remain == DATA_W'(1));
endmodule

// File: rtl/txbyte_link.sv
module txbyte_link #(
  parameter int          DATA_W    = 8,
  parameter int          ADDR_W    = 2,
  parameter logic [7:0]  START_CMD = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic              readyFlag,
  output logic              busy,
  output logic              donePulse,
  output logic              errPulse,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  input  logic              outReady
);
  import txbyte_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_CMD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_DATA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_CLR  = ADDR_W'(2);

  txCtl_s ctl;
  logic startWr, dataWr, clrWr, holdIsZero, lastPayload;

  assign startWr = regWrEn && regAddr == ADDR_CMD && regWrData == DATA_W'(START_CMD);
  assign dataWr  = regWrEn && regAddr == ADDR_DATA;
  assign clrWr   = regWrEn && regAddr == ADDR_CLR;

  txbyte_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .startWr(startWr), .dataWr(dataWr),
    .outReady(outReady), .holdIsZero(holdIsZero), .lastPayload(lastPayload),
    .ctl(ctl), .busy(busy), .sendActive(outValid)
  );

  txbyte_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clrWr(clrWr), .wrData(regWrData),
    .holdByte(outData), .holdIsZero(holdIsZero), .lastPayload(lastPayload),
    .flagQ(readyFlag), .doneQ(donePulse), .errQ(errPulse)
  );
endmodule

// File: rtl/txbyte_link_chk.sv
module txbyte_link_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              readyFlag,
  input logic              busy,
  input logic              donePulse,
  input logic              errPulse,
  input logic              outValid,
  input logic [DATA_W-1:0] outData,
  input logic              outReady
);
  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> busy);

  // R3
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyFlag) |-> $past(regWrEn && regAddr == ADDR_W'(2)));

  // R4
  stream_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !busy && !outValid);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> !donePulse);

  // R8
  err_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> $past(regWrEn && regAddr == ADDR_W'(1)));
endmodule

bind txbyte_link txbyte_link_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/txbyte_link_tb_top.sv
module txbyte_link_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic outReady = 1'b0;
  logic readyFlag, busy, donePulse, errPulse, outValid;
  logic [7:0] outData;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txbyte_link dut_i (.*);

  // fields: length, payload0, payload1, payload2, stall cycles
  localparam logic [39:0] VECS [5] = '{
    {8'd2, 8'h12, 8'h34, 8'h00, 8'd0},
    {8'd1, 8'hA5, 8'h00, 8'h00, 8'd2},
    {8'd3, 8'h01, 8'hFF, 8'h7E, 8'd1},
    {8'd0, 8'h00, 8'h00, 8'h00, 8'd0},
    {8'd3, 8'h00, 8'h80, 8'h55, 8'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic consume(input int stall);
    for (int s = 0; s < stall; s++) @(negedge clk);
    outReady = 1'b1;
    @(negedge clk);
    outReady = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input int stall, input bit isLast);
    busWr(2'd2, 8'h00);
    check("R3 flag cleared", readyFlag, 1'b0);
    busWr(2'd1, b);
    check("R4 byte offered", {outValid, outData}, {1'b1, b});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check("R5 no flag while pending", readyFlag, 1'b0);
      check("R4 byte held", {outValid, outData}, {1'b1, b});
    end
    consume(0);
    if (isLast) begin
      check("R6 done pulse", {donePulse, busy}, 2'b10);
      @(negedge clk);
      check("R6 done one cycle", donePulse, 1'b0);
    end else begin
      check("R5 flag raised again", {readyFlag, outValid}, 2'b10);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state", {busy, readyFlag, outValid, donePulse, errPulse}, 5'b0);

    // R2 wrong command ignored; R3 address 3 ignored
    busWr(2'd0, 8'h02);
    check("R2 wrong cmd ignored", {busy, readyFlag}, 2'b00);
    busWr(2'd3, 8'h03);
    check("R3 addr3 ignored", {busy, readyFlag, errPulse}, 3'b000);

    foreach (VECS[i]) begin
      logic [7:0] len, p[3], st;
      {len, p[0], p[1], p[2], st} = VECS[i];
      busWr(2'd0, 8'h03);
      check("R2 start", {busy, readyFlag}, 2'b11);
      sendByte(len, int'(st), len == 0);   // R7 when len is 0
      for (int k = 0; k < int'(len); k++)
        sendByte(p[k], int'(st), k == int'(len) - 1);
      check("R6 idle after packet", busy, 1'b0);
    end

    // R8 data write while idle
    busWr(2'd1, 8'h99);
    check("R8 err when idle", {errPulse, outValid}, 2'b10);
    @(negedge clk);
    check("R8 err one cycle", errPulse, 1'b0);

    // R8 write while pending, R9 start while busy
    busWr(2'd0, 8'h03);
    busWr(2'd1, 8'd2);
    consume(0);
    busWr(2'd1, 8'h11);
    busWr(2'd1, 8'h22);
    check("R8 err when pending", {errPulse, outData}, {1'b1, 8'h11});
    busWr(2'd0, 8'h03);
    check("R9 start ignored", {busy, outValid, outData}, {1'b1, 1'b1, 8'h11});
    consume(0);
    check("R9 count unchanged", {busy, donePulse, readyFlag}, 3'b101);
    busWr(2'd1, 8'h33);
    consume(1);
    check("R8 R9 ends after two payload", {busy, donePulse}, 2'b01);

    // R3 set wins over clear in same cycle
    busWr(2'd0, 8'h03);
    busWr(2'd2, 8'h00);
    busWr(2'd1, 8'd1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd2; outReady = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; outReady = 1'b0;
    check("R3 set beats clear", readyFlag, 1'b1);
    busWr(2'd1, 8'h44);
    consume(0);
    check("R6 final done", {busy, donePulse}, 2'b01);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule